// File: doc/BRIEF.md
# Dual-Operation Condensed Word Executor

This block executes one 16-bit condensed word that carries two register-to-register operations. Each half names a 4-bit operation and a 3-bit source register. The destination is always register 0, so the halves behave as two accumulator steps. The first half (A) runs before the second half (B), and B sees A's result. Both halves act on an eight-entry register file of 64-bit registers that the block holds. Every register can be seen on a flat output bus. Ordinary instructions elsewhere in the pipeline put their results into that file through a single write port.

The width of the operands does not come from the word. It comes from a sticky 3-bit operand-type register. An explicit set-type command loads that register, and so does the type report of the most recent ordinary memory-reference instruction. Type codes 0 to 3 select 8, 16, 32 or 64-bit integer operation on the low bits of the registers. Multiply and divide operations, and any type code above 3, are not handled here. They raise an unsupported flag and leave all state unchanged.

Each word gives a one-cycle done pulse together with its unsupported and source-error status. The compare operations update a set of less, equal and greater flags.

Top module: `condensed_pair_exec`

## Requirements
- R1: A word presented with `word_valid` high in a cycle is executed in that cycle. The register file, `flag_*`, `unsupported` and `src_error` take their results at that clock edge, and `done` is high for exactly the following cycle. The word layout is: [15:12] op A, [11:9] source A, [7:4] op B, [3:1] source B.
- R2: Half A executes before half B, and B operates on the register values that A produced. Only register 0 and the named source registers can change.
- R3: The type register resets to 3. A set-type command loads it. A memory-reference type report loads it when no set-type command occurs in the same cycle, because set-type has priority. A word that arrives in the same cycle as a type update uses the old type. The type register is visible on `cur_type`.
- R4: Type codes 0, 1, 2 and 3 select operand widths of 8, 16, 32 and 64 bits. With any other type code a word changes no register and no flag, and it raises `unsupported`.
- R5: Load (0010) sign-extends the low type-width bits of the source into register 0. Unsigned load (1010) zero-extends them.
- R6: Insert (1000) replaces only the low type-width bits of register 0 with those of the source, and keeps the upper bits of register 0.
- R7: Swap (0000) exchanges the low type-width bits of register 0 and the source. Store (0011) copies the low type-width bits of register 0 into the source. In both cases the upper bits of each register are kept.
- R8: Add (0100), subtract (0101, r0 minus source), XOR (1011), AND (1100) and OR (1101) act on the low type-width bits. The result is written to register 0, sign-extended from the type width.
- R9: Compare (0001, signed) and unsigned compare (1001) set exactly one of `flag_lt`, `flag_eq`, `flag_gt` (r0 against source) and modify no register. When a word contains no compare, the flags keep their values. If both halves compare, half B sets the flags.
- R10: Operations 0110, 0111, 1110 and 1111 raise `unsupported` and skip only their own half.
- R11: A source field of 0 raises `src_error` and skips only that half. When an operation is unsupported, that check takes priority over this one.
- R12: Word bits 8 and 0 are reserved and have no effect on the result.
- R13: After reset all registers read zero, all flags are low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | Execute `word_in` this cycle |
| word_in | input | 16 | Condensed word holding two operations |
| set_type_valid | input | 1 | Explicit set-type command |
| set_type_code | input | 3 | Type code of the set-type command |
| mem_type_valid | input | 1 | Memory-reference instruction reports its type |
| mem_type_code | input | 3 | Reported type code |
| wr_en | input | 1 | Writeback from ordinary instructions (ignored while `word_valid`) |
| wr_idx | input | 3 | Writeback register index |
| wr_data | input | 64 | Writeback data |
| regs_flat | output | 512 | Register i at bits [i*64 +: 64] |
| cur_type | output | 3 | Current operand type |
| flag_lt | output | 1 | Last compare: r0 below source |
| flag_eq | output | 1 | Last compare: equal |
| flag_gt | output | 1 | Last compare: r0 above source |
| done | output | 1 | Pulse, one cycle after a word |
| unsupported | output | 1 | Last word had an unsupported type or operation |
| src_error | output | 1 | Last word had a half with source 0 |

## Verification
Register contents, flags, `unsupported`, `src_error` and `cur_type` all become valid at the first clock edge after the stimulus, and `done` is high during the cycle that follows that edge. The bench drives inputs on the falling edge and holds them for one full period. It reads every result on the next falling edge, half a cycle after the edge that registered it. To confirm that `done` is a single-cycle pulse, the bench checks it once more one full cycle later. Each scenario first loads its own register values through the writeback port, so the expected values do not depend on the order in which the scenarios run.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

   typedef enum logic [3:0] {
      OP_SWAP  = 4'b0000,
      OP_CMP   = 4'b0001,
      OP_LOAD  = 4'b0010,
      OP_STORE = 4'b0011,
      OP_ADD   = 4'b0100,
      OP_SUB   = 4'b0101,
      OP_MUL   = 4'b0110,
      OP_DIV   = 4'b0111,
      OP_INS   = 4'b1000,
      OP_UCMP  = 4'b1001,
      OP_ULOAD = 4'b1010,
      OP_XOR   = 4'b1011,
      OP_AND   = 4'b1100,
      OP_OR    = 4'b1101,
      OP_MULX  = 4'b1110,
      OP_DIVX  = 4'b1111
   } cpe_op_e;

   // One half of the condensed word; the last bit is reserved.
   typedef struct packed {
      logic [3:0] op;
      logic [2:0] src;
      logic       rsvd;
   } cpe_half_t;

   localparam int HALF_W = $bits(cpe_half_t);
   localparam int WORD_W = 2 * HALF_W;

   // Operations executed elsewhere; here they only raise a flag.
   function automatic logic op_external(input logic [3:0] op);
      return (op == OP_MUL) || (op == OP_DIV) || (op == OP_MULX) || (op == OP_DIVX);
   endfunction

   function automatic logic op_compares(input logic [3:0] op);
      return (op == OP_CMP) || (op == OP_UCMP);
   endfunction

endpackage

// File: rtl/cpe_type_reg.sv
module cpe_type_reg #(
   parameter int TW         = 3,
   parameter int TYPE_RESET = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_valid,
   input  logic [TW-1:0] set_code,
   input  logic          mem_valid,
   input  logic [TW-1:0] mem_code,
   output logic [TW-1:0] cur
);

   initial begin
      if (TYPE_RESET >= (1 << TW)) $error("TYPE_RESET does not fit in TW bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cur <= TW'(TYPE_RESET);
      else if (set_valid) cur <= set_code;
      else if (mem_valid) cur <= mem_code;
   end

   assert_settype_loads_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      set_valid |=> cur == $past(set_code));

   assert_memtype_loads_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !set_valid) |=> cur == $past(mem_code));

   assert_type_sticky_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_valid && !set_valid) |=> $stable(cur));

endmodule

// File: rtl/cpe_regfile.sv
module cpe_regfile #(
   parameter int XLEN = 64,
   parameter int NREG = 8,
   localparam int IW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_en,
   input  logic [XLEN-1:0] upd_regs [NREG],
   input  logic            wr_en,
   input  logic [IW-1:0]   wr_idx,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] regs [NREG]
);

   for (genvar i = 0; i < NREG; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           regs[i] <= '0;
         else if (upd_en)                      regs[i] <= upd_regs[i];
         else if (wr_en && wr_idx == IW'(i))   regs[i] <= wr_data;
      end
   end

endmodule

// File: rtl/cpe_half_unit.sv
module cpe_half_unit
   import cpe_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int NREG   = 8,
   parameter int TW     = 3,
   parameter int NTYPES = 4,
   localparam int IW    = $clog2(NREG)
) (
   input  logic            en,
   input  logic [3:0]      op,
   input  logic [IW-1:0]   src,
   input  logic [TW-1:0]   typ,
   input  logic [XLEN-1:0] regs_in  [NREG],
   output logic [XLEN-1:0] regs_out [NREG],
   output logic            cmp_hit,
   output logic            lt,
   output logic            eq,
   output logic            gt,
   output logic            unsup,
   output logic            err
);

   logic [XLEN-1:0] mask, sbit, a, b, fa, fb;

   // Width mask and sign-bit position chosen by the operand type.
   always_comb begin
      mask = '1;
      for (int k = 0; k < NTYPES; k++) begin
         if (typ == TW'(k)) mask = {XLEN{1'b1}} >> (XLEN - (8 << k));
      end
      sbit = mask ^ (mask >> 1);
   end

   function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] v,
                                           input logic [XLEN-1:0] m,
                                           input logic [XLEN-1:0] sb,
                                           input logic sgn);
      logic [XLEN-1:0] lo;
      lo = v & m;
      return (sgn && |(v & sb)) ? (lo | ~m) : lo;
   endfunction

   function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] keep_hi,
                                             input logic [XLEN-1:0] take_lo,
                                             input logic [XLEN-1:0] m);
      return (keep_hi & ~m) | (take_lo & m);
   endfunction

   always_comb begin
      a  = regs_in[0];
      b  = regs_in[src];
      fa = fit(a, mask, sbit, 1'b1);
      fb = fit(b, mask, sbit, 1'b1);
   end

   always_comb begin
      regs_out = regs_in;
      cmp_hit  = 1'b0;
      lt       = 1'b0;
      eq       = 1'b0;
      gt       = 1'b0;
      unsup    = 1'b0;
      err      = 1'b0;
      if (en) begin
         if (op_external(op)) begin
            unsup = 1'b1;
         end else if (src == '0) begin
            err = 1'b1;
         end else begin
            case (cpe_op_e'(op))
               OP_SWAP: begin
                  regs_out[0]   = merge(a, b, mask);
                  regs_out[src] = merge(b, a, mask);
               end
               OP_CMP: begin
                  cmp_hit = 1'b1;
                  lt = $signed(fa) <  $signed(fb);
                  gt = $signed(fa) >  $signed(fb);
                  eq = fa == fb;
               end
               OP_UCMP: begin
                  cmp_hit = 1'b1;
                  lt = (a & mask) <  (b & mask);
                  gt = (a & mask) >  (b & mask);
                  eq = (a & mask) == (b & mask);
               end
               OP_LOAD:  regs_out[0]   = fit(b, mask, sbit, 1'b1);
               OP_ULOAD: regs_out[0]   = fit(b, mask, sbit, 1'b0);
               OP_STORE: regs_out[src] = merge(b, a, mask);
               OP_INS:   regs_out[0]   = merge(a, b, mask);
               OP_ADD:   regs_out[0]   = fit(a + b, mask, sbit, 1'b1);
               OP_SUB:   regs_out[0]   = fit(a - b, mask, sbit, 1'b1);
               OP_XOR:   regs_out[0]   = fit(a ^ b, mask, sbit, 1'b1);
               OP_AND:   regs_out[0]   = fit(a & b, mask, sbit, 1'b1);
               OP_OR:    regs_out[0]   = fit(a | b, mask, sbit, 1'b1);
               default:  regs_out = regs_in;
            endcase
         end
      end
   end

endmodule

// File: rtl/condensed_pair_exec.sv
module condensed_pair_exec
   import cpe_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int TYPE_RESET = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_valid,
   input  logic [15:0]        word_in,
   input  logic               set_type_valid,
   input  logic [2:0]         set_type_code,
   input  logic               mem_type_valid,
   input  logic [2:0]         mem_type_code,
   input  logic               wr_en,
   input  logic [2:0]         wr_idx,
   input  logic [XLEN-1:0]    wr_data,
   output logic [8*XLEN-1:0]  regs_flat,
   output logic [2:0]         cur_type,
   output logic               flag_lt,
   output logic               flag_eq,
   output logic               flag_gt,
   output logic               done,
   output logic               unsupported,
   output logic               src_error
);

   localparam int NREG   = 8;
   localparam int TW     = 3;
   localparam int NHALF  = 2;
   localparam int NTYPES = $clog2(XLEN / 8) + 1;

   initial begin
      if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) $error("XLEN must be a power of two of at least 8");
      if (NTYPES > (1 << TW)) $error("XLEN too wide for the type code");
      if (WORD_W != 16) $error("condensed word must be 16 bits");
   end

   logic [XLEN-1:0] regs [NREG];
   logic [XLEN-1:0] stg  [NHALF+1][NREG];
   logic [NHALF-1:0] h_cmp, h_lt, h_eq, h_gt, h_uns, h_err;
   logic             type_ok, exec_en;
   logic [TW-1:0]    typ;
   cpe_half_t        halves [NHALF];
   logic             rsvd_unused;

   assign halves[0]   = word_in[WORD_W-1:HALF_W];
   assign halves[1]   = word_in[HALF_W-1:0];
   assign rsvd_unused = halves[0].rsvd ^ halves[1].rsvd;

   cpe_type_reg #(.TW(TW), .TYPE_RESET(TYPE_RESET)) u_type (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_valid (set_type_valid),
      .set_code  (set_type_code),
      .mem_valid (mem_type_valid),
      .mem_code  (mem_type_code),
      .cur       (typ)
   );

   assign type_ok = typ < TW'(NTYPES);
   assign exec_en = word_valid && type_ok;
   assign stg[0]  = regs;

   for (genvar g = 0; g < NHALF; g++) begin : g_half
      cpe_half_unit #(.XLEN(XLEN), .NREG(NREG), .TW(TW), .NTYPES(NTYPES)) u_half (
         .en       (exec_en),
         .op       (halves[g].op),
         .src      (halves[g].src),
         .typ      (typ),
         .regs_in  (stg[g]),
         .regs_out (stg[g+1]),
         .cmp_hit  (h_cmp[g]),
         .lt       (h_lt[g]),
         .eq       (h_eq[g]),
         .gt       (h_gt[g]),
         .unsup    (h_uns[g]),
         .err      (h_err[g])
      );
   end

   cpe_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (exec_en),
      .upd_regs (stg[NHALF]),
      .wr_en    (wr_en && !word_valid),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .regs     (regs)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_flat
      assign regs_flat[i*XLEN +: XLEN] = regs[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_lt     <= 1'b0;
         flag_eq     <= 1'b0;
         flag_gt     <= 1'b0;
         done        <= 1'b0;
         unsupported <= 1'b0;
         src_error   <= 1'b0;
      end else begin
         done <= word_valid;
         if (word_valid) begin
            unsupported <= !type_ok || (|h_uns);
            src_error   <= |h_err;
         end
         if (h_cmp[1]) begin
            {flag_lt, flag_eq, flag_gt} <= {h_lt[1], h_eq[1], h_gt[1]};
         end else if (h_cmp[0]) begin
            {flag_lt, flag_eq, flag_gt} <= {h_lt[0], h_eq[0], h_gt[0]};
         end
      end
   end

   assign cur_type = typ;

   assert_done_pulse_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> done);

   assert_done_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |=> !done);

   assert_bad_type_inert_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !type_ok) |=> ($stable(regs_flat) && unsupported));

   assert_flags_onehot_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_lt, flag_eq, flag_gt}));

   assert_flags_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |=> $stable({flag_lt, flag_eq, flag_gt}));

   assert_upper_regs_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && halves[0].src != 3'd7 && halves[1].src != 3'd7)
         |=> $stable(regs_flat[7*XLEN +: XLEN]));

endmodule

// File: tb/condensed_pair_exec_bench.sv
module condensed_pair_exec_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         word_valid = 1'b0;
   logic [15:0]  word_in = '0;
   logic         set_type_valid = 1'b0;
   logic [2:0]   set_type_code = '0;
   logic         mem_type_valid = 1'b0;
   logic [2:0]   mem_type_code = '0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_idx = '0;
   logic [63:0]  wr_data = '0;
   logic [511:0] regs_flat;
   logic [2:0]   cur_type;
   logic         flag_lt, flag_eq, flag_gt, done, unsupported, src_error;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   condensed_pair_exec u_condensed_pair_exec (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
      .set_type_valid(set_type_valid), .set_type_code(set_type_code),
      .mem_type_valid(mem_type_valid), .mem_type_code(mem_type_code),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .regs_flat(regs_flat), .cur_type(cur_type),
      .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_gt(flag_gt),
      .done(done), .unsupported(unsupported), .src_error(src_error)
   );

   function automatic logic [63:0] rd(input int i);
      return regs_flat[i*64 +: 64];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input int i, input logic [63:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'(i); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_type(input logic [2:0] t);
      @(negedge clk);
      set_type_valid = 1'b1; set_type_code = t;
      @(negedge clk);
      set_type_valid = 1'b0;
   endtask

   // Drives one word for one cycle; results are read at the following falling edge.
   task automatic run(input logic [15:0] w);
      @(negedge clk);
      word_valid = 1'b1; word_in = w;
      @(negedge clk);
      word_valid = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) check("R13 reg", rd(i), 64'h0);
      check("R13 flags", {flag_lt, flag_eq, flag_gt}, 3'b000);
      check("R13 done", done, 1'b0);
      check("R3 reset type", cur_type, 3'd3);
   endtask

   task automatic t_load_add;
      set_type(3'd3);
      put(1, 64'd5); put(2, 64'd7); put(0, 64'h99);
      run(16'h2244);
      check("R2 load then add", rd(0), 64'd12);
      check("R1 done pulse", done, 1'b1);
      check("R1 status clear", {unsupported, src_error}, 2'b00);
      @(negedge clk);
      check("R1 done one cycle", done, 1'b0);
   endtask

   task automatic t_extend_insert;
      set_type(3'd0);
      put(3, 64'h80); put(4, 64'h12);
      run(16'h2688);
      check("R6 insert over sign-loaded byte", rd(0), 64'hFFFF_FFFF_FFFF_FF12);
   endtask

   task automatic t_uload_swap;
      set_type(3'd1);
      put(0, 64'h0); put(5, 64'hABCD_8001); put(6, 64'h1111_2222_3333_4444);
      run(16'hAA0C);
      check("R5 zero-extend then R7 swap r0", rd(0), 64'h4444);
      check("R7 swap source", rd(6), 64'h1111_2222_3333_8001);
   endtask

   task automatic t_compare;
      set_type(3'd3);
      put(0, 64'h4444); put(1, 64'd5); put(2, 64'h4444); put(7, '1);
      run(16'h1E1E);
      check("R9 signed gt", {flag_lt, flag_eq, flag_gt}, 3'b001);
      check("R9 regs untouched", rd(0), 64'h4444);
      run(16'h129E);
      check("R9 unsigned lt, half B wins", {flag_lt, flag_eq, flag_gt}, 3'b100);
      run(16'h1414);
      check("R9 eq", {flag_lt, flag_eq, flag_gt}, 3'b010);
      run(16'h2244);
      check("R9 flags hold", {flag_lt, flag_eq, flag_gt}, 3'b010);
   endtask

   task automatic t_store_sub;
      set_type(3'd2);
      put(0, 64'h4444); put(1, 64'd5); put(2, 64'hFFFF_FFFF_0000_0007);
      run(16'h5234);
      check("R8 sub", rd(0), 64'h443F);
      check("R7 store keeps upper", rd(2), 64'hFFFF_FFFF_0000_443F);
   endtask

   task automatic t_byte_arith;
      set_type(3'd0);
      put(0, 64'h7F); put(1, 64'd1); put(2, 64'h3F);
      run(16'h4242);
      check("R8 byte add wrap sign-extends", rd(0), 64'hFFFF_FFFF_FFFF_FF81);
      run(16'hC4B2);
      check("R8 and then xor", rd(0), 64'h0);
   endtask

   task automatic t_unsup_op;
      set_type(3'd3);
      put(0, 64'h10); put(1, 64'd5);
      run(16'h6242);
      check("R10 half A skipped", rd(0), 64'h15);
      check("R10 flag", {unsupported, src_error}, 2'b10);
      run(16'h42F2);
      check("R10 half B skipped", rd(0), 64'h1A);
   endtask

   task automatic t_src_err;
      set_type(3'd3);
      put(0, 64'h10); put(1, 64'd5);
      run(16'h40D2);
      check("R11 only half B ran", rd(0), 64'h15);
      check("R11 flag", {unsupported, src_error}, 2'b01);
   endtask

   task automatic t_bad_type;
      set_type(3'd5);
      check("R3 type loaded", cur_type, 3'd5);
      put(0, 64'h99); put(1, 64'd5); put(2, 64'd7);
      run(16'h2244);
      check("R4 bad type no change", rd(0), 64'h99);
      check("R4 unsupported", unsupported, 1'b1);
   endtask

   task automatic t_type_reg;
      @(negedge clk);
      set_type_valid = 1'b1; set_type_code = 3'd1;
      mem_type_valid = 1'b1; mem_type_code = 3'd2;
      @(negedge clk);
      set_type_valid = 1'b0; mem_type_valid = 1'b0;
      check("R3 set-type priority", cur_type, 3'd1);
      @(negedge clk);
      mem_type_valid = 1'b1; mem_type_code = 3'd0;
      @(negedge clk);
      mem_type_valid = 1'b0;
      check("R3 memref report", cur_type, 3'd0);
      put(3, 64'h180);
      @(negedge clk);
      word_valid = 1'b1; word_in = 16'h2626;
      set_type_valid = 1'b1; set_type_code = 3'd2;
      @(negedge clk);
      word_valid = 1'b0; set_type_valid = 1'b0;
      check("R3 word uses old type", rd(0), 64'hFFFF_FFFF_FFFF_FF80);
      check("R3 new type after", cur_type, 3'd2);
   endtask

   task automatic t_reserved;
      set_type(3'd3);
      put(1, 64'd5); put(2, 64'd7);
      run(16'h2345);
      check("R12 reserved bits ignored", rd(0), 64'd12);
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_add();
      t_extend_insert();
      t_uload_swap();
      t_compare();
      t_store_sub();
      t_byte_arith();
      t_unsup_op();
      t_src_err();
      t_bad_type();
      t_type_reg();
      t_reserved();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule